// File: doc/BRIEF.md
# Command-Byte Register Slave for a Two-Wire Management Bus

This block is a target device on an SMBus/I2C-style two-wire bus. It samples SCL and SDA with the system clock and finds START and STOP conditions itself. It also decides when to pull SDA low, and it holds a small byte-wide register file that the bus master reads and writes. The seven-bit device address is fixed in its upper five bits. Its two lowest bits come from strap pins, so up to four copies can share one bus.

A write transaction starts with the address byte. A command byte comes next. If bit 7 of the command byte is clear, its low bits load a register pointer, and every data byte after it is stored at the pointer, which then advances. If bit 7 is set, the low bits give a base pointer and the block enters block-write mode. The next byte is a count N, and exactly N data bytes are stored at consecutive locations. A read transaction has no command byte. It returns bytes from wherever an earlier write left the pointer, and it keeps going until the master declines a byte and ends the transfer.

On-chip logic can read any register at any time through a second, combinational read port.

Top module: `smb_cmd_slave`

## Requirements
- R1: After reset, SDA is released (`sda_pull_low` = 0), every register reads 0x00 and the pointer is 0.
- R2: The address byte is acknowledged only when its upper seven bits equal {1,0,1,1,1,`strap_lo[1]`,`strap_lo[0]`}, with bit 0 the read/write flag (0 = write, 1 = read). On a mismatch, the address and every later byte are left unacknowledged, and no register changes until the next START or STOP.
- R3: In a write transaction, the slave pulls SDA low through the ninth clock of the address, the command byte and every accepted data byte. It does not pull SDA low while data bits are being received.
- R4: A command byte with bit 7 = 0 sets the pointer to its bits 3:0. Each following data byte is stored at the pointer, and then the pointer advances by one.
- R5: The pointer advances by one after each byte written or read, and it wraps from 15 to 0.
- R6: A command byte with bit 7 = 1 sets the base pointer to its bits 3:0. The next byte is a count N, and the N bytes after it are stored at consecutive locations. Any further data byte, including the first when N = 0, is not acknowledged and is not stored.
- R7: In a read transaction, the slave sends the register at the pointer MSB first and advances the pointer. While the master acknowledges, the next register follows. The pointer left by an earlier transaction is kept.
- R8: After the master leaves a read byte unacknowledged, the slave keeps SDA released until the next START.
- R9: A repeated START sends the slave back to address matching, and the pointer is kept.
- R10: A STOP (SDA rising while SCL is high) releases SDA on the next cycle and ends the transaction.
- R11: The SDA drive changes only while SCL is low.
- R12: `host_data` shows the current content of the register selected by `host_addr`, and a bus write becomes visible there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_lo | input | 2 | Strap pins giving the two lowest address bits |
| sda_pull_low | output | 1 | 1 = drive the open-drain SDA pad low |
| host_addr | input | REG_AW | On-chip read port address |
| host_data | output | 8 | On-chip read port data |

## Verification
The assertions take the following for granted about the bus:
- SDA changes only while SCL is low, except when the master makes a START or a STOP.
- Each SCL level lasts longer than the synchronizer latency.
- The master never makes a START or STOP while the slave is pulling SDA low.

The bench's bit-level master meets all three conditions by construction. It keeps each quarter of a 200 ns SCL period at five system clocks, and it changes SDA one quarter period after SCL falls. It issues START and STOP only when it holds SCL and SDA itself. The bus line is modelled as the wired-AND of the master's drive and the slave's pull-down.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } smb_state_e;

   typedef enum logic [1:0] {
      ROLE_ADDR,
      ROLE_CMD,
      ROLE_COUNT,
      ROLE_DATA
   } smb_role_e;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } smb_evt_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
   import smb_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_in,
   input  logic     sda_in,
   output smb_evt_t evt
);
   localparam int LINES = 2;

   logic [LINES-1:0]              raw;
   logic [LINES-1:0][STAGES-1:0]  pipe;
   logic [LINES-1:0]              cur;
   logic [LINES-1:0]              prev;

   assign raw = {sda_in, scl_in};

   generate
      for (genvar li = 0; li < LINES; li++) begin : g_line
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe[li] <= '1;
               prev[li] <= 1'b1;
            end else begin
               pipe[li] <= {pipe[li][STAGES-2:0], raw[li]};
               prev[li] <= pipe[li][STAGES-1];
            end
         end
         assign cur[li] = pipe[li][STAGES-1];
      end
   endgenerate

   always_comb begin
      evt.scl      = cur[0];
      evt.sda      = cur[1];
      evt.scl_rise = cur[0] & ~prev[0];
      evt.scl_fall = ~cur[0] & prev[0];
      evt.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
      evt.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
   end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0]    mem [DEPTH];
   logic [DEPTH-1:0] sel;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         assign sel[e] = we && (waddr == AW'(e));
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem[e] <= '0;
            else if (sel[e])
               mem[e] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
   import smb_pkg::*;
#(
   parameter int         AW      = 4,
   parameter logic [4:0] ADDR_HI = 5'b10111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  smb_evt_t          evt,
   input  logic [1:0]        strap,
   output logic              drive,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [BYTE_W-1:0] wdata,
   output logic [AW-1:0]     ptr,
   input  logic [BYTE_W-1:0] rd_data
);
   localparam int CW = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0] FULL = CW'(BYTE_W);

   smb_state_e        state;
   smb_role_e         role;
   logic [CW-1:0]     bitcnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] remain;
   logic              block;
   logic              rw;
   logic              master_ack;
   logic              addr_hit;

   assign addr_hit = (rx_sh[7:1] == {ADDR_HI, strap});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         role       <= ROLE_ADDR;
         bitcnt     <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         remain     <= '0;
         block      <= 1'b0;
         rw         <= 1'b0;
         master_ack <= 1'b0;
         drive      <= 1'b0;
         ptr        <= '0;
         we         <= 1'b0;
         waddr      <= '0;
         wdata      <= '0;
      end else begin
         we <= 1'b0;
         if (evt.stop) begin
            state <= ST_IDLE;
            drive <= 1'b0;
         end else if (evt.start) begin
            state  <= ST_RX;
            role   <= ROLE_ADDR;
            bitcnt <= '0;
            drive  <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (evt.scl_rise && bitcnt < FULL) begin
                     rx_sh  <= {rx_sh[BYTE_W-2:0], evt.sda};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (evt.scl_fall && bitcnt == FULL) begin
                     case (role)
                        ROLE_ADDR: begin
                           if (addr_hit) begin
                              rw    <= rx_sh[0];
                              role  <= ROLE_CMD;
                              drive <= 1'b1;
                              state <= ST_RX_ACK;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        ROLE_CMD: begin
                           ptr   <= rx_sh[AW-1:0];
                           block <= rx_sh[7];
                           role  <= rx_sh[7] ? ROLE_COUNT : ROLE_DATA;
                           drive <= 1'b1;
                           state <= ST_RX_ACK;
                        end
                        ROLE_COUNT: begin
                           remain <= rx_sh;
                           role   <= ROLE_DATA;
                           drive  <= 1'b1;
                           state  <= ST_RX_ACK;
                        end
                        default: begin
                           if (block && remain == '0) begin
                              state <= ST_IDLE;
                           end else begin
                              we    <= 1'b1;
                              waddr <= ptr;
                              wdata <= rx_sh;
                              ptr   <= ptr + 1'b1;
                              if (block)
                                 remain <= remain - 1'b1;
                              drive <= 1'b1;
                              state <= ST_RX_ACK;
                           end
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (evt.scl_fall) begin
                     if (rw) begin
                        drive  <= ~rd_data[BYTE_W-1];
                        tx_sh  <= {rd_data[BYTE_W-2:0], 1'b0};
                        bitcnt <= CW'(1);
                        state  <= ST_TX;
                     end else begin
                        drive  <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (evt.scl_fall) begin
                     if (bitcnt < FULL) begin
                        drive  <= ~tx_sh[BYTE_W-1];
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end else begin
                        drive <= 1'b0;
                        ptr   <= ptr + 1'b1;
                        state <= ST_TX_ACK;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (evt.scl_rise) begin
                     master_ack <= ~evt.sda;
                  end else if (evt.scl_fall) begin
                     if (master_ack) begin
                        drive  <= ~rd_data[BYTE_W-1];
                        tx_sh  <= {rd_data[BYTE_W-2:0], 1'b0};
                        bitcnt <= CW'(1);
                        state  <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R11
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.scl && $past(evt.scl)) |-> $stable(drive));

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> !drive);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !drive);

   // R3
   ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (state == ST_RX_ACK || state == ST_TX));

   // R4
   write_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (state == ST_RX_ACK && drive));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.start && !evt.stop) |=> (state == ST_RX && bitcnt == '0 && !drive));
endmodule

// File: rtl/smb_cmd_slave.sv
module smb_cmd_slave
   import smb_pkg::*;
#(
   parameter int         REG_AW      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] DEV_ADDR_HI = 5'b10111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic [1:0]        strap_lo,
   output logic              sda_pull_low,
   input  logic [REG_AW-1:0] host_addr,
   output logic [7:0]        host_data
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REG_AW < 1 || REG_AW > 7) begin : g_bad_aw
         $error("REG_AW must lie between 1 and 7");
      end
   endgenerate

   smb_evt_t          evt;
   logic              wr_en;
   logic [REG_AW-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic [REG_AW-1:0] cur_ptr;
   logic [BYTE_W-1:0] ptr_data;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_in),
      .sda_in (sda_in),
      .evt    (evt)
   );

   smb_slave_fsm #(.AW(REG_AW), .ADDR_HI(DEV_ADDR_HI)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .strap   (strap_lo),
      .drive   (sda_pull_low),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .ptr     (cur_ptr),
      .rd_data (ptr_data)
   );

   smb_regfile #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .raddr_a (cur_ptr),
      .rdata_a (ptr_data),
      .raddr_b (host_addr),
      .rdata_b (host_data)
   );
endmodule

// File: tb/tb_smb_cmd_slave.sv
`timescale 1ns/1ps
module tb_smb_cmd_slave;
   localparam int Q = 50;
   localparam logic [7:0] AW_WR = 8'hBA;
   localparam logic [7:0] AW_RD = 8'hBB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [3:0] host_addr = '0;
   logic [7:0] host_data;
   logic       sda_pull_low;
   logic       sda_bus;
   int         n_cmp = 0;
   int         n_bad = 0;
   int         hold_viol = 0;

   always #5 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull_low;

   smb_cmd_slave dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_in       (m_scl),
      .sda_in       (sda_bus),
      .strap_lo     (2'b01),
      .sda_pull_low (sda_pull_low),
      .host_addr    (host_addr),
      .host_data    (host_data)
   );

   always @(sda_pull_low) if (m_scl && rst_n) hold_viol++;

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic host_rd(input logic [3:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_data;
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; #Q; m_scl = 1'b1; #Q; #Q; m_scl = 1'b0; #Q;
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; b = sda_bus; #Q; m_scl = 1'b0; #Q;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q; #Q;
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(x);
      ack = ~x;
   endtask

   task automatic rd_byte(output logic [7:0] b, input logic give_ack);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         bit_in(x);
         b[i] = x;
      end
      bit_out(~give_ack);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 sda released", sda_pull_low, 1'b0);
      for (int a = 0; a < 16; a++) begin
         host_rd(a[3:0], d);
         chk("R1 R12 reg zero", d, 8'h00);
      end
   endtask

   task automatic t_ptr_write();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(AW_WR, ack); chk("R2 addr ack", ack, 1'b1);
      wr_byte(8'h02, ack); chk("R3 cmd ack", ack, 1'b1);
      wr_byte(8'h11, ack); chk("R3 data ack", ack, 1'b1);
      wr_byte(8'h22, ack); chk("R3 data ack", ack, 1'b1);
      wr_byte(8'h33, ack); chk("R3 data ack", ack, 1'b1);
      bus_stop();
      chk("R10 released after stop", sda_pull_low, 1'b0);
      host_rd(4'd2, d); chk("R4 reg2", d, 8'h11);
      host_rd(4'd3, d); chk("R4 reg3", d, 8'h22);
      host_rd(4'd4, d); chk("R12 reg4", d, 8'h33);
   endtask

   task automatic t_wrap();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(AW_WR, ack);
      wr_byte(8'h0F, ack);
      wr_byte(8'hA1, ack);
      wr_byte(8'hA2, ack);
      wr_byte(8'hA3, ack); chk("R5 ack after wrap", ack, 1'b1);
      bus_stop();
      host_rd(4'd15, d); chk("R5 reg15", d, 8'hA1);
      host_rd(4'd0, d);  chk("R5 reg0", d, 8'hA2);
      host_rd(4'd1, d);  chk("R5 reg1", d, 8'hA3);
   endtask

   task automatic t_block();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(AW_WR, ack);
      wr_byte(8'h86, ack); chk("R6 block cmd ack", ack, 1'b1);
      wr_byte(8'h02, ack); chk("R6 count ack", ack, 1'b1);
      wr_byte(8'h5A, ack); chk("R6 data ack", ack, 1'b1);
      wr_byte(8'hC3, ack); chk("R6 data ack", ack, 1'b1);
      wr_byte(8'h77, ack); chk("R6 excess nack", ack, 1'b0);
      bus_stop();
      host_rd(4'd6, d); chk("R6 reg6", d, 8'h5A);
      host_rd(4'd7, d); chk("R6 reg7", d, 8'hC3);
      host_rd(4'd8, d); chk("R6 reg8 untouched", d, 8'h00);
      bus_start();
      wr_byte(AW_WR, ack);
      wr_byte(8'h89, ack);
      wr_byte(8'h00, ack); chk("R6 zero count ack", ack, 1'b1);
      wr_byte(8'h99, ack); chk("R6 zero count nack", ack, 1'b0);
      bus_stop();
      host_rd(4'd9, d); chk("R6 reg9 untouched", d, 8'h00);
   endtask

   task automatic t_read();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(AW_WR, ack);
      wr_byte(8'h02, ack);
      bus_stop();
      bus_start();
      wr_byte(AW_RD, ack); chk("R2 read addr ack", ack, 1'b1);
      rd_byte(d, 1'b1); chk("R7 read reg2", d, 8'h11);
      rd_byte(d, 1'b1); chk("R7 read reg3", d, 8'h22);
      rd_byte(d, 1'b0); chk("R7 read reg4", d, 8'h33);
      chk("R8 released after nack", sda_pull_low, 1'b0);
      rd_byte(d, 1'b0); chk("R8 silent after nack", d, 8'hFF);
      bus_stop();
   endtask

   task automatic t_restart();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(AW_WR, ack);
      wr_byte(8'h0F, ack);
      bus_start();
      wr_byte(AW_RD, ack); chk("R9 addr after restart", ack, 1'b1);
      rd_byte(d, 1'b1); chk("R9 read reg15", d, 8'hA1);
      rd_byte(d, 1'b0); chk("R5 read wraps to reg0", d, 8'hA2);
      bus_stop();
      bus_start();
      wr_byte(AW_RD, ack);
      rd_byte(d, 1'b0); chk("R7 kept pointer reg1", d, 8'hA3);
      bus_stop();
   endtask

   task automatic t_mismatch();
      logic ack; logic [7:0] d;
      bus_start();
      wr_byte(8'hBC, ack); chk("R2 foreign addr nack", ack, 1'b0);
      wr_byte(8'h04, ack); chk("R2 ignored byte nack", ack, 1'b0);
      wr_byte(8'hEE, ack); chk("R2 ignored byte nack", ack, 1'b0);
      bus_stop();
      host_rd(4'd4, d); chk("R2 reg4 unchanged", d, 8'h33);
      bus_start();
      wr_byte(AW_WR, ack); chk("R10 usable after stop", ack, 1'b1);
      bus_stop();
   endtask

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog act=timeout exp=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_ptr_write();
      t_wrap();
      t_block();
      t_read();
      t_restart();
      t_mismatch();
      chk("R11 drive steady while SCL high", hold_viol, 0);
      finish_run();
   end
endmodule